// File: doc/BRIEF.md
# BCD Calendar Clock Core

This block holds wall-clock time and calendar in eight byte-wide BCD registers: hundredths of a second, seconds, minutes, hours, weekday, date, month and year. A 100 Hz enable pulse advances the hundredths register. Any rollover is carried into the next field, one field per clock cycle, by a small sequencer. Month lengths follow the calendar, and a year counts as a leap year when its value is divisible by four.

A parallel load port writes all eight registers in one cycle, and a parallel read port presents them continuously as one 64-bit image. Register i occupies bits 8*i+7 down to 8*i. The hours register carries a 12/24-hour mode bit and an AM/PM flag. The weekday register carries two control bits. One stops the clock. The other decides whether an external active-low reset pin may raise a transfer-abort output for the serial access logic that sits around this core.

The sequencer has eight states. ST_IDLE waits. A tick (clock running) or a held-over tick moves it to ST_HUND. ST_HUND, ST_SEC, ST_MIN, ST_HOUR, ST_DATE and ST_MONTH each update their own field. Each one moves to the following state when that field wrapped and back to ST_IDLE when it did not. ST_HOUR also advances the weekday when the day turns over. ST_YEAR always returns to ST_IDLE. A load sends any state to ST_IDLE.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the image reads 64'h00_01_01_31_00_00_00_00. That is 00:00:00.00 in 24-hour mode, weekday 1, date 01, month 01, year 00, with the stop bit and the reset-ignore bit both 1. xfer_abort is 0.
- R2: ld_en writes all eight registers at the next edge, and unused bits are forced to 0. Each register keeps only the bits set in its mask: hundredths FF, seconds 7F, minutes 7F, hours BF, weekday 37, date 3F, month 1F, year FF.
- R3: A load takes priority over a tick in the same cycle and over a carry in progress. The loaded image is final, and no increment is applied to it.
- R4: On a tick sampled at edge k, hundredths count 00..99 at edge k+1. A wrap carries into seconds at k+2, and seconds (00..59) wrap into minutes (00..59) at k+3. A field that does not wrap ends the carry.
- R5: With hours bit 7 = 0 (24-hour mode), hours hold BCD 00..23 in bits 5:0, 09 steps to 10, and 23 wraps to 00 with a day carry.
- R6: With hours bit 7 = 1 (12-hour mode), bits 4:0 hold 01..12 and bit 5 is PM. 11 steps to 12 and flips PM, and 12 steps to 01 without a flip. Only 11 PM to 12 AM carries into the day.
- R7: The weekday (bits 2:0) counts 1..7 and wraps 7 to 1 on each day carry, leaving bits 5:4 unchanged.
- R8: The date wraps to 01 after 30 for months 04, 06, 09 and 11, and after 31 for the other months except February. That wrap carries into the month.
- R9: In February the date wraps after 29 when the year value is divisible by 4 (00, 12, 24 ...), and after 28 otherwise.
- R10: The month counts 01..12, and 12 wraps to 01 with a carry into the year. The year counts 00..99, and 99 wraps to 00.
- R11: While weekday bit 5 is 1, ticks are ignored and the time does not change.
- R12: xfer_abort is 1 exactly when ext_rst_n is 0 and weekday bit 4 is 0.
- R13: A tick that arrives while a carry is in progress is held and applied once the sequencer returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_100hz | input | 1 | One-cycle enable pulse at 100 Hz |
| ld_en | input | 1 | Load all registers from ld_data |
| ld_data | input | 64 | Load image, register i in bits 8*i+7:8*i |
| ext_rst_n | input | 1 | External active-low abort request |
| rd_data | output | 64 | Snapshot of all eight registers |
| xfer_abort | output | 1 | Qualified abort request to transfer logic |

## Verification
A load is visible on rd_data one edge after ld_en is sampled. A tick sampled at edge k changes hundredths at k+1, and each later field changes one edge after the field before it, so a full cascade settles by edge k+7. xfer_abort is combinational from its inputs. The bench drives inputs and samples outputs on falling edges. It checks the per-field timing at exactly k+1 and k+2 after a tick, waits ten cycles before comparing any settled image, and checks xfer_abort in the same cycle as its inputs change.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int NREG   = 8;
    localparam int REG_W  = 8;
    localparam int IMG_W  = NREG * REG_W;

    localparam logic [IMG_W-1:0] REG_MASK  = 64'hFF1F_3F37_BF7F_7FFF;
    localparam logic [IMG_W-1:0] RESET_IMG = 64'h0001_0131_0000_0000;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HUND,
        ST_SEC,
        ST_MIN,
        ST_HOUR,
        ST_DATE,
        ST_MONTH,
        ST_YEAR
    } rtc_stage_e;

    function automatic logic [REG_W-1:0] bcd_inc(input logic [REG_W-1:0] v);
        if (v[3:0] == 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        else
            return {v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic logic is_leap(input logic [REG_W-1:0] yr);
        logic [6:0] bin;
        bin = ({3'b000, yr[7:4]} * 7'd10) + {3'b000, yr[3:0]};
        return (bin[1:0] == 2'b00);
    endfunction

endpackage

// File: rtl/rtc_month_len.sv
module rtc_month_len
    import rtc_pkg::*;
(
    input  logic [REG_W-1:0] month,
    input  logic [REG_W-1:0] year,
    output logic [REG_W-1:0] last_date
);

    always_comb begin
        unique case (month)
            8'h02:                      last_date = is_leap(year) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: last_date = 8'h30;
            default:                    last_date = 8'h31;
        endcase
    end

endmodule

// File: rtl/rtc_time_step.sv
module rtc_time_step
    import rtc_pkg::*;
(
    input  rtc_stage_e        stage,
    input  logic [IMG_W-1:0]  cur,
    output logic [NREG-1:0]   wr_en,
    output logic [IMG_W-1:0]  nxt,
    output logic              carry
);

    logic [REG_W-1:0] hs, sc, mn, hr, dy, dt, mo, yr;
    logic [REG_W-1:0] date_lim;
    logic [REG_W-1:0] hval, hnew;
    logic             pm_new;
    logic [2:0]       wday;

    assign hs = cur[ 7: 0];
    assign sc = cur[15: 8];
    assign mn = cur[23:16];
    assign hr = cur[31:24];
    assign dy = cur[39:32];
    assign dt = cur[47:40];
    assign mo = cur[55:48];
    assign yr = cur[63:56];

    rtc_month_len u_month_len (
        .month     (mo),
        .year      (yr),
        .last_date (date_lim)
    );

    always_comb begin
        wr_en  = '0;
        nxt    = cur;
        carry  = 1'b0;
        hval   = '0;
        hnew   = '0;
        pm_new = 1'b0;
        wday   = 3'd1;
        unique case (stage)
            ST_IDLE: begin
            end
            ST_HUND: begin
                wr_en[0] = 1'b1;
                if (hs == 8'h99) begin
                    nxt[7:0] = 8'h00;
                    carry    = 1'b1;
                end else begin
                    nxt[7:0] = bcd_inc(hs);
                end
            end
            ST_SEC: begin
                wr_en[1] = 1'b1;
                if (sc == 8'h59) begin
                    nxt[15:8] = 8'h00;
                    carry     = 1'b1;
                end else begin
                    nxt[15:8] = bcd_inc(sc);
                end
            end
            ST_MIN: begin
                wr_en[2] = 1'b1;
                if (mn == 8'h59) begin
                    nxt[23:16] = 8'h00;
                    carry      = 1'b1;
                end else begin
                    nxt[23:16] = bcd_inc(mn);
                end
            end
            ST_HOUR: begin
                wr_en[3] = 1'b1;
                if (hr[7]) begin
                    hval   = {3'b000, hr[4], hr[3:0]};
                    pm_new = hr[5];
                    if (hval == 8'h11) begin
                        hnew   = 8'h12;
                        pm_new = ~hr[5];
                        carry  = hr[5];
                    end else if (hval == 8'h12) begin
                        hnew = 8'h01;
                    end else begin
                        hnew = bcd_inc(hval);
                    end
                    nxt[31:24] = {1'b1, 1'b0, pm_new, hnew[4], hnew[3:0]};
                end else begin
                    hval = {2'b00, hr[5:0]};
                    if (hval == 8'h23) begin
                        hnew  = 8'h00;
                        carry = 1'b1;
                    end else begin
                        hnew = bcd_inc(hval);
                    end
                    nxt[31:24] = {2'b00, hnew[5:0]};
                end
                if (carry) begin
                    wr_en[4]   = 1'b1;
                    wday       = (dy[2:0] == 3'd7) ? 3'd1 : dy[2:0] + 3'd1;
                    nxt[39:32] = {2'b00, dy[5:4], 1'b0, wday};
                end
            end
            ST_DATE: begin
                wr_en[5] = 1'b1;
                if (dt == date_lim) begin
                    nxt[47:40] = 8'h01;
                    carry      = 1'b1;
                end else begin
                    nxt[47:40] = bcd_inc(dt);
                end
            end
            ST_MONTH: begin
                wr_en[6] = 1'b1;
                if (mo == 8'h12) begin
                    nxt[55:48] = 8'h01;
                    carry      = 1'b1;
                end else begin
                    nxt[55:48] = bcd_inc(mo);
                end
            end
            ST_YEAR: begin
                wr_en[7]   = 1'b1;
                nxt[63:56] = (yr == 8'h99) ? 8'h00 : bcd_inc(yr);
            end
        endcase
    end

endmodule

// File: rtl/rtc_seq_fsm.sv
module rtc_seq_fsm
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       osc_off,
    input  logic       load,
    input  logic       carry,
    output rtc_stage_e stage
);

    rtc_stage_e state, state_nxt;
    logic       pend;
    logic       go;

    assign go = (tick && !osc_off) || pend;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:  state_nxt = (!load && go)    ? ST_HUND  : ST_IDLE;
            ST_HUND:  state_nxt = (!load && carry) ? ST_SEC   : ST_IDLE;
            ST_SEC:   state_nxt = (!load && carry) ? ST_MIN   : ST_IDLE;
            ST_MIN:   state_nxt = (!load && carry) ? ST_HOUR  : ST_IDLE;
            ST_HOUR:  state_nxt = (!load && carry) ? ST_DATE  : ST_IDLE;
            ST_DATE:  state_nxt = (!load && carry) ? ST_MONTH : ST_IDLE;
            ST_MONTH: state_nxt = (!load && carry) ? ST_YEAR  : ST_IDLE;
            ST_YEAR:  state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            pend  <= 1'b0;
        end else begin
            state <= state_nxt;
            if (load || state == ST_IDLE)
                pend <= 1'b0;
            else if (tick && !osc_off)
                pend <= 1'b1;
        end
    end

    always_comb begin
        stage = state;
    end

    // R3
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (state == ST_IDLE));

    // R11
    osc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && osc_off && !pend) |=> (state == ST_IDLE));

    // R10
    year_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_YEAR) |=> (state == ST_IDLE));

    // R13
    held_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && tick && !osc_off && !load) |=> pend);

endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
    import rtc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_100hz,
    input  logic             ld_en,
    input  logic [IMG_W-1:0] ld_data,
    input  logic             ext_rst_n,
    output logic [IMG_W-1:0] rd_data,
    output logic             xfer_abort
);

    localparam int DAY_IDX   = 4;
    localparam int STOP_BIT  = DAY_IDX * REG_W + 5;
    localparam int IGNR_BIT  = DAY_IDX * REG_W + 4;

    logic [REG_W-1:0] rf [NREG];
    logic [IMG_W-1:0] cur_img;
    logic [IMG_W-1:0] step_img;
    logic [NREG-1:0]  step_we;
    logic             step_carry;
    rtc_stage_e       stage;

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                rf[i] <= RESET_IMG[i*REG_W +: REG_W];
            else if (ld_en)
                rf[i] <= ld_data[i*REG_W +: REG_W] & REG_MASK[i*REG_W +: REG_W];
            else if (step_we[i])
                rf[i] <= step_img[i*REG_W +: REG_W];
        end
        assign cur_img[i*REG_W +: REG_W] = rf[i];
    end

    rtc_seq_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_100hz),
        .osc_off (cur_img[STOP_BIT]),
        .load    (ld_en),
        .carry   (step_carry),
        .stage   (stage)
    );

    rtc_time_step u_step (
        .stage (stage),
        .cur   (cur_img),
        .wr_en (step_we),
        .nxt   (step_img),
        .carry (step_carry)
    );

    assign rd_data    = cur_img;
    assign xfer_abort = !ext_rst_n && !cur_img[IGNR_BIT];

    // R2
    load_image_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> (rd_data == ($past(ld_data) & REG_MASK)));

    // R12
    abort_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[IGNR_BIT] |-> !xfer_abort);

    // R4
    hund_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stage == ST_HUND && !ld_en) |=> (rd_data[7:0] != $past(rd_data[7:0])));

    // R6
    hour12_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stage == ST_HOUR && !ld_en && rd_data[31]) |=> (rd_data[28:24] != 5'd0));

endmodule

// File: tb/test_bcd_rtc_core.sv
`timescale 1ns/1ps
module test_bcd_rtc_core;

    logic        clk = 1'b0;
    logic        rst_n, tick_100hz, ld_en, ext_rst_n;
    logic [63:0] ld_data;
    logic [63:0] rd_data;
    logic        xfer_abort;
    int          n_chk = 0;
    int          n_bad = 0;

    always #2.5 clk = ~clk;

    bcd_rtc_core i_bcd_rtc_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_100hz (tick_100hz),
        .ld_en      (ld_en),
        .ld_data    (ld_data),
        .ext_rst_n  (ext_rst_n),
        .rd_data    (rd_data),
        .xfer_abort (xfer_abort)
    );

    // {requirement number, loaded image, image after one tick}
    localparam int NVEC = 21;
    localparam logic [135:0] VEC [NVEC] = '{
        {8'd4,  64'h2403_1513_1020_3041, 64'h2403_1513_1020_3042}, // R4
        {8'd4,  64'h2403_1513_1020_3099, 64'h2403_1513_1020_3100}, // R4
        {8'd4,  64'h2403_1513_1020_5999, 64'h2403_1513_1021_0000}, // R4
        {8'd5,  64'h2403_1513_2359_5999, 64'h2403_1614_0000_0000}, // R5
        {8'd5,  64'h2403_1513_0959_5999, 64'h2403_1513_1000_0000}, // R5
        {8'd6,  64'h2403_1513_9159_5999, 64'h2403_1513_B200_0000}, // R6
        {8'd6,  64'h2403_1513_B259_5999, 64'h2403_1513_A100_0000}, // R6
        {8'd6,  64'h2403_1513_B159_5999, 64'h2403_1614_9200_0000}, // R6
        {8'd6,  64'h2403_1513_8959_5999, 64'h2403_1513_9000_0000}, // R6
        {8'd7,  64'h2403_1517_2359_5999, 64'h2403_1611_0000_0000}, // R7
        {8'd8,  64'h2404_3013_2359_5999, 64'h2405_0114_0000_0000}, // R8
        {8'd8,  64'h2401_3013_2359_5999, 64'h2401_3114_0000_0000}, // R8
        {8'd8,  64'h2401_3113_2359_5999, 64'h2402_0114_0000_0000}, // R8
        {8'd8,  64'h2409_3013_2359_5999, 64'h2410_0114_0000_0000}, // R8
        {8'd9,  64'h2402_2813_2359_5999, 64'h2402_2914_0000_0000}, // R9
        {8'd9,  64'h2402_2913_2359_5999, 64'h2403_0114_0000_0000}, // R9
        {8'd9,  64'h2302_2813_2359_5999, 64'h2303_0114_0000_0000}, // R9
        {8'd9,  64'h0002_2813_2359_5999, 64'h0002_2914_0000_0000}, // R9
        {8'd9,  64'h2602_2813_2359_5999, 64'h2603_0114_0000_0000}, // R9
        {8'd10, 64'h2412_3113_2359_5999, 64'h2501_0114_0000_0000}, // R10
        {8'd10, 64'h9912_3113_2359_5999, 64'h0001_0114_0000_0000}  // R10
    };

    task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic load_img(input logic [63:0] v);
        @(negedge clk);
        ld_en   = 1'b1;
        ld_data = v;
        @(negedge clk);
        ld_en   = 1'b0;
    endtask

    task automatic tick_once();
        @(negedge clk);
        tick_100hz = 1'b1;
        @(negedge clk);
        tick_100hz = 1'b0;
    endtask

    task automatic settle();
        repeat (10) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n      = 1'b0;
        tick_100hz = 1'b0;
        ld_en      = 1'b0;
        ld_data    = '0;
        ext_rst_n  = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset image and abort output
        check64("R1 image", rd_data, 64'h0001_0131_0000_0000);
        check64("R1 abort", {63'd0, xfer_abort}, 64'd0);

        // R1 clock stopped after reset: a tick has no effect
        tick_once();
        settle();
        check64("R1 stopped", rd_data, 64'h0001_0131_0000_0000);

        for (int i = 0; i < NVEC; i++) begin
            load_img(VEC[i][127:64]);
            tick_once();
            settle();
            check64($sformatf("R%0d vector %0d", VEC[i][135:128], i), rd_data, VEC[i][63:0]);
        end

        // R2 masking of unused bits, visible right after the load edge
        load_img(64'hFFFF_FFFF_FFFF_FFFF);
        check64("R2 mask", rd_data, 64'hFF1F_3F37_BF7F_7FFF);

        // R4 per-field timing: hundredths at k+1, seconds at k+2
        load_img(64'h2403_1513_2359_5999);
        tick_once();
        @(negedge clk);
        check64("R4 k+1", {48'd0, rd_data[15:0]}, 64'h5900);
        @(negedge clk);
        check64("R4 k+2", {40'd0, rd_data[23:0]}, 64'h59_0000);
        settle();

        // R11 stop bit set: tick ignored
        load_img(64'h2403_1533_1020_3041);
        tick_once();
        settle();
        check64("R11 stopped", rd_data, 64'h2403_1533_1020_3041);

        // R3 load and tick in the same cycle
        @(negedge clk);
        tick_100hz = 1'b1;
        ld_en      = 1'b1;
        ld_data    = 64'h2403_1513_1020_3099;
        @(negedge clk);
        tick_100hz = 1'b0;
        ld_en      = 1'b0;
        settle();
        check64("R3 same cycle", rd_data, 64'h2403_1513_1020_3099);

        // R3 load during a carry in progress
        load_img(64'h2403_1513_2359_5999);
        tick_once();
        @(negedge clk);
        load_img(64'h2403_1513_1020_3041);
        settle();
        check64("R3 mid carry", rd_data, 64'h2403_1513_1020_3041);

        // R13 second tick while busy is held
        load_img(64'h2403_1513_1020_3099);
        tick_once();
        @(negedge clk);
        tick_100hz = 1'b1;
        @(negedge clk);
        tick_100hz = 1'b0;
        settle();
        check64("R13 held tick", rd_data, 64'h2403_1513_1020_3101);

        // R12 abort gating
        load_img(64'h2403_1503_1020_3041);
        ext_rst_n = 1'b0;
        @(negedge clk);
        check64("R12 enabled low", {63'd0, xfer_abort}, 64'd1);
        ext_rst_n = 1'b1;
        @(negedge clk);
        check64("R12 enabled high", {63'd0, xfer_abort}, 64'd0);
        load_img(64'h2403_1533_1020_3041);
        ext_rst_n = 1'b0;
        @(negedge clk);
        check64("R12 ignored", {63'd0, xfer_abort}, 64'd0);
        ext_rst_n = 1'b1;

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule